// File: doc/BRIEF.md
# Partitioned Serial Symmetric FIR Filter

This block is an even-length FIR filter whose coefficients are mirror-symmetric (or mirror-antisymmetric). It does not give each tap its own multiplier. The coefficient pairs are split into a small number of serial partitions. Each partition owns a single multiplier and an accumulator, and it steps through its own contiguous run of pairs, one pair per fast clock.

For each pair, the two mirrored delay-line samples are combined before the multiply. They are summed when the coefficients are symmetric and differenced when they are antisymmetric. This halves the number of products per sample. Setting the partition count to one gives a fully serial filter.

The partial sums can be combined in one of two ways:
- **Adder-tree mode:** the partial sums meet in an adder stage when the output is captured.
- **Cascade mode:** each partition folds in the finished sum of the partition after it. This spends one more fast cycle per sample instead of the adder stage.

The result is rounded and saturated to 12 bits, held in an output register, and announced with a one-cycle strobe. Samples arrive on a valid strobe. The fast clock must give at least the per-sample cycle budget between two strobes.

Top module: `fir_serial_sym`

## Requirements
- R1: With `ANTISYM=0` the output before rounding is y = sum over k of c[k]·(x[k] + x[2P−1−k]). Here P is `NUM_PAIRS`, x[0] is the newest accepted sample and c[k] is `COEFS[k]`. With `ANTISYM=1` the plus becomes a minus.
- R2: The delay line advances only on a cycle where `valid_i` is high. `data_i` on other cycles has no effect on any later output.
- R3: The entries `PART_LEN[0..NUM_PARTS-1]` sum to `NUM_PAIRS`. Partition p handles the contiguous pairs that start after those of partitions 0..p−1. With a single partition, the filter computes the same R1 result.
- R4: In adder-tree mode, `valid_o` goes high exactly max(PART_LEN)+1 clock edges after the edge that accepted the sample.
- R5: In cascade mode with more than one partition, each partition's accumulator adds the finished sum of the next partition one cycle after its own last product. The latency is `PART_LEN[0]`+2 edges. The sizes must be strictly descending, except that the last two may be equal.
- R6: The output is floor((y + 2^(FRAC_W−1)) / 2^FRAC_W), clamped to the range [−2048, 2047] as a two's-complement 12-bit value.
- R7: `valid_o` is high for exactly one cycle per accepted sample. `data_o` changes only on that cycle.
- R8: While `rst_ni` is low, `valid_o` and `data_o` are 0 and the delay line is cleared.
- R9: Samples spaced exactly by the latency of R4/R5 are all processed correctly, with one output each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 12 | Signed input sample |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Signed rounded, saturated result |

## Verification
The bench builds three instances from the same five-pair coefficient set and feeds them the same stream:
- **Adder-tree instance:** two partitions of sizes 3 and 2.
- **Cascade instance:** the same 3/2 split.
- **Fully serial instance:** a single partition of 5 pairs, with antisymmetric coefficients.

Together the instances reach both combining paths, the extra cascade cycle, the subtracting pre-adder and three distinct latencies. The coefficient and shift values are chosen so that:
- unit impulses land exactly on the rounding half-point;
- full-scale runs drive both saturation limits.

// File: rtl/fir_ser_pkg.sv
package fir_ser_pkg;
  localparam int MAX_PARTS = 8;

  typedef int unsigned part_len_t [MAX_PARTS];

  typedef enum logic {
    COMB_TREE    = 1'b0,
    COMB_CASCADE = 1'b1
  } comb_mode_e;

  // first pair index owned by partition p
  function automatic int unsigned part_base(part_len_t lens, int unsigned p);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < MAX_PARTS; i++) if (i < p) s += lens[i];
    return s;
  endfunction

  function automatic int unsigned part_max(part_len_t lens, int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned i = 0; i < MAX_PARTS; i++) if (i < n && lens[i] > m) m = lens[i];
    return m;
  endfunction

  // edges from sample accept to visible valid_o
  function automatic int unsigned sample_cycles(part_len_t lens, int unsigned n, comb_mode_e m);
    if (m == COMB_CASCADE && n > 1) return lens[0] + 2;
    return part_max(lens, n) + 1;
  endfunction
endpackage

// File: rtl/fir_ser_taps.sv
module fir_ser_taps #(
  parameter int DATA_W   = 12,
  parameter int NUM_TAPS = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] tap_o [NUM_TAPS]
);
  logic signed [DATA_W-1:0] line_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_TAPS; i++) line_q[i] <= '0;
    end else if (shift_i) begin
      line_q[0] <= data_i;
      for (int i = 1; i < NUM_TAPS; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign tap_o = line_q;
endmodule

// File: rtl/fir_ser_seq.sv
module fir_ser_seq #(
  parameter int LAST   = 4,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [STEP_W-1:0] step_o,
  output logic              active_o,
  output logic              load_o
);
  logic [STEP_W-1:0] step_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      step_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (step_q == STEP_W'(LAST)) active_q <= 1'b0;
      else                         step_q   <= step_q + 1'b1;
    end
  end

  assign step_o   = step_q;
  assign active_o = active_q;
  assign load_o   = active_q && (step_q == STEP_W'(LAST));
endmodule

// File: rtl/fir_ser_mac.sv
module fir_ser_mac #(
  parameter int DATA_W  = 12,
  parameter int COEF_W  = 10,
  parameter int ACC_W   = 27,
  parameter bit ANTISYM = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] near_i,
  input  logic signed [DATA_W-1:0] far_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic                     mac_en_i,
  input  logic                     first_i,
  input  logic                     casc_en_i,
  input  logic signed [ACC_W-1:0]  casc_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int OP_W = DATA_W + 1;

  logic signed [OP_W-1:0]        pre;
  logic signed [OP_W+COEF_W-1:0] prod;
  logic signed [ACC_W-1:0]       acc_q;

  generate
    if (ANTISYM) begin : g_sub
      assign pre = OP_W'(near_i) - OP_W'(far_i);
    end else begin : g_add
      assign pre = OP_W'(near_i) + OP_W'(far_i);
    end
  endgenerate

  assign prod = pre * coef_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (mac_en_i)  acc_q <= first_i ? ACC_W'(prod) : acc_q + ACC_W'(prod);
    else if (casc_en_i) acc_q <= acc_q + casc_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fir_serial_sym.sv
module fir_serial_sym
  import fir_ser_pkg::*;
#(
  parameter int         DATA_W    = 12,
  parameter int         COEF_W    = 10,
  parameter int         NUM_PAIRS = 5,
  parameter int         FRAC_W    = 9,
  parameter int         NUM_PARTS = 2,
  parameter part_len_t  PART_LEN  = '{3, 2, 0, 0, 0, 0, 0, 0},
  parameter comb_mode_e MODE      = COMB_TREE,
  parameter bit         ANTISYM   = 1'b0,
  parameter logic signed [COEF_W-1:0] COEFS [NUM_PAIRS] = '{-10'sd8, 10'sd24, 10'sd96, 10'sd200, 10'sd256}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int NUM_TAPS = 2 * NUM_PAIRS;
  localparam int LAST     = sample_cycles(PART_LEN, NUM_PARTS, MODE) - 1;
  localparam int STEP_W   = $clog2(LAST + 2);
  localparam int ACC_W    = DATA_W + 1 + COEF_W + $clog2(NUM_PAIRS + 1) + 1;
  localparam bit CASCADE  = (MODE == COMB_CASCADE) && (NUM_PARTS > 1);
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((1 << (DATA_W-1)) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = -(ACC_W+1)'(1 << (DATA_W-1));
  localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(1 << (FRAC_W-1));

  logic signed [DATA_W-1:0] tap [NUM_TAPS];
  logic signed [ACC_W-1:0]  acc [NUM_PARTS];
  logic [STEP_W-1:0]        step;
  logic                     active, load;

  fir_ser_taps #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS)) u_taps (
    .clk_i, .rst_ni, .shift_i(valid_i), .data_i, .tap_o(tap)
  );

  fir_ser_seq #(.LAST(LAST), .STEP_W(STEP_W)) u_seq (
    .clk_i, .rst_ni, .start_i(valid_i), .step_o(step), .active_o(active), .load_o(load)
  );

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    localparam int BASE = int'(part_base(PART_LEN, p));
    localparam int LEN  = int'(PART_LEN[p]);

    logic signed [DATA_W-1:0] near_s, far_s;
    logic signed [COEF_W-1:0] coef_s;
    logic signed [ACC_W-1:0]  casc_s;
    logic                     casc_en;

    // tap-pair select for this partition
    always_comb begin
      near_s = '0;
      far_s  = '0;
      coef_s = '0;
      for (int i = 0; i < LEN; i++) begin
        if (int'(step) == i) begin
          near_s = tap[BASE + i];
          far_s  = tap[NUM_TAPS - 1 - BASE - i];
          coef_s = COEFS[BASE + i];
        end
      end
    end

    if (CASCADE && p < NUM_PARTS - 1) begin : g_casc
      assign casc_s  = acc[p+1];
      assign casc_en = active && (int'(step) == LEN);
    end else begin : g_nocasc
      assign casc_s  = '0;
      assign casc_en = 1'b0;
    end

    fir_ser_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .ANTISYM(ANTISYM)) u_mac (
      .clk_i, .rst_ni,
      .near_i   (near_s),
      .far_i    (far_s),
      .coef_i   (coef_s),
      .mac_en_i (active && (int'(step) < LEN)),
      .first_i  (step == '0),
      .casc_en_i(casc_en),
      .casc_i   (casc_s),
      .acc_o    (acc[p])
    );
  end

  logic signed [ACC_W-1:0] total;
  logic signed [ACC_W:0]   rnd, shf;
  logic signed [DATA_W-1:0] sat;

  generate
    if (CASCADE) begin : g_tot_casc
      assign total = acc[0];
    end else begin : g_tot_tree
      always_comb begin
        total = '0;
        for (int p = 0; p < NUM_PARTS; p++) total = total + acc[p];
      end
    end
  endgenerate

  assign rnd = (ACC_W+1)'(total) + HALF;
  assign shf = rnd >>> FRAC_W;

  always_comb begin
    if (shf > SAT_HI)      sat = SAT_HI[DATA_W-1:0];
    else if (shf < SAT_LO) sat = SAT_LO[DATA_W-1:0];
    else                   sat = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load;
      if (load) data_o <= sat;
    end
  end
endmodule

// File: rtl/fir_serial_sym_chk.sv
module fir_serial_sym_chk
  import fir_ser_pkg::*;
#(
  parameter int         DATA_W    = 12,
  parameter int         NUM_PARTS = 2,
  parameter part_len_t  PART_LEN  = '{3, 2, 0, 0, 0, 0, 0, 0},
  parameter comb_mode_e MODE      = COMB_TREE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  localparam int SC = int'(sample_cycles(PART_LEN, NUM_PARTS, MODE));

  logic [7:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             since_q <= '0;
    else if (valid_i)                        since_q <= 8'd1;
    else if (since_q != '0 && since_q != '1) since_q <= since_q + 8'd1;
  end

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // also covers R5 when MODE is cascade
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(since_q) == 8'(SC));

  assert_emit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 8'(SC)) |=> valid_o);

  assert_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (since_q == '0 || since_q >= 8'(SC)));
endmodule

bind fir_serial_sym fir_serial_sym_chk #(
  .DATA_W(DATA_W), .NUM_PARTS(NUM_PARTS), .PART_LEN(PART_LEN), .MODE(MODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/fir_serial_sym_test.sv
module fir_serial_sym_test;
  import fir_ser_pkg::*;

  localparam int NP = 5;
  localparam int NT = 2 * NP;
  localparam int FRAC = 9;
  localparam logic signed [9:0] TB_COEF [NP] = '{-10'sd8, 10'sd24, 10'sd96, 10'sd200, 10'sd256};
  localparam int CI [NP] = '{-8, 24, 96, 200, 256};
  localparam int NSTIM = 48;
  localparam int STIM [NSTIM] = '{
    512, 0, 0, 0, 0, 0, 0, 0, 0, 0,
    1, 0, 0, 0, 0, -1, 0, 0, 0, 0,
    2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047,
    -2048, -2048, -2048, -2048, -2048, -2048,
    1000, -1000, 1000, -1000, 1000, -1000,
    3, -5, 7, 1, -300, 77};
  localparam int LAT [3] = '{4, 5, 6};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [11:0] data_i = '0;
  logic v_o [3];
  logic signed [11:0] d_o [3];

  int tests = 0, fails = 0, cyc = 0;
  int x [NT];
  int exp_q [3][$];
  int due_q [3][$];
  int held [3];
  int got [3];
  int sent = 0;
  string tag [3] = '{"R1 R4 R6", "R5", "R1 R3"};

  always #2ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  fir_serial_sym #(.COEFS(TB_COEF), .MODE(COMB_TREE)) uut (
    .clk_i, .rst_ni, .valid_i, .data_i, .valid_o(v_o[0]), .data_o(d_o[0]));
  fir_serial_sym #(.COEFS(TB_COEF), .MODE(COMB_CASCADE)) uut_casc (
    .clk_i, .rst_ni, .valid_i, .data_i, .valid_o(v_o[1]), .data_o(d_o[1]));
  fir_serial_sym #(.COEFS(TB_COEF), .NUM_PARTS(1), .PART_LEN('{5, 0, 0, 0, 0, 0, 0, 0}),
                   .ANTISYM(1'b1)) uut_ser (
    .clk_i, .rst_ni, .valid_i, .data_i, .valid_o(v_o[2]), .data_o(d_o[2]));

  function automatic int rsat(longint y);
    longint r;
    r = (y + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic report(string req, int act, int expv, string what);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // per-cycle output monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int i = 0; i < 3; i++) begin
        if (v_o[i]) begin
          got[i]++;
          if (due_q[i].size() == 0) begin
            report("R7", 1, 0, "unexpected valid_o");
          end else begin
            report(tag[i], cyc, due_q[i][0], "valid_o cycle");
            report(tag[i], int'(d_o[i]), exp_q[i][0], "data_o");
            void'(due_q[i].pop_front());
            void'(exp_q[i].pop_front());
          end
          held[i] = int'(d_o[i]);
        end else begin
          if (due_q[i].size() != 0 && due_q[i][0] <= cyc) begin
            report(tag[i], 0, 1, "missing valid_o");
            void'(due_q[i].pop_front());
            void'(exp_q[i].pop_front());
          end
          if (int'(d_o[i]) != held[i]) report("R2 R7", int'(d_o[i]), held[i], "data_o hold");
        end
      end
    end
  end

  task automatic send(input int s, input int gap);
    longint ys, ya;
    valid_i = 1'b1;
    data_i  = 12'(s);
    @(posedge clk_i);
    @(negedge clk_i);
    for (int k = NT - 1; k > 0; k--) x[k] = x[k-1];
    x[0] = s;
    ys = 0;
    ya = 0;
    for (int k = 0; k < NP; k++) begin
      ys += longint'(CI[k]) * (x[k] + x[NT-1-k]);
      ya += longint'(CI[k]) * (x[k] - x[NT-1-k]);
    end
    exp_q[0].push_back(rsat(ys)); due_q[0].push_back(cyc + LAT[0]);
    exp_q[1].push_back(rsat(ys)); due_q[1].push_back(cyc + LAT[1]);
    exp_q[2].push_back(rsat(ya)); due_q[2].push_back(cyc + LAT[2]);
    sent++;
    valid_i = 1'b0;
    data_i  = ~data_i;                       // R2: junk while idle
    repeat (gap - 1) begin
      @(posedge clk_i);
      @(negedge clk_i);
      data_i = data_i ^ 12'h5a5;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      report("R8", int'(v_o[i]), 0, "valid_o in reset");
      report("R8", int'(d_o[i]), 0, "data_o in reset");
      exp_q[i].delete();
      due_q[i].delete();
      held[i] = 0;
      got[i] = 0;
    end
    for (int k = 0; k < NT; k++) x[k] = 0;
    sent = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic drain(string req);
    repeat (10) @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      report(req, due_q[i].size(), 0, "outputs outstanding");
      report(req, got[i], sent, "output count");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) x[k] = 0;
    for (int i = 0; i < 3; i++) begin held[i] = 0; got[i] = 0; end
    do_reset();

    // main table, relaxed spacing
    for (int n = 0; n < NSTIM; n++) send(STIM[n], 8);
    drain("R1 R3 R6");

    // R8: reset mid-stream clears history, then impulse replays from empty line
    send(700, 8);
    send(-900, 3);
    do_reset();
    send(512, 8);
    for (int n = 0; n < 10; n++) send(0, 8);
    drain("R8");

    // R2: long idle with toggling data, then impulse response must be clean
    repeat (40) begin @(negedge clk_i); data_i = data_i + 12'd37; end
    send(-2048, 8);
    for (int n = 0; n < 10; n++) send(0, 8);
    drain("R2");

    // R9: back-to-back at the slowest instance's budget
    for (int n = 0; n < NSTIM; n++) send(STIM[NSTIM-1-n], LAT[2]);
    drain("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule